// File: doc/BRIEF.md
# Instruction Stream Prefetch Buffer

This block works next to a direct-mapped instruction cache and lowers the number of first-touch misses. The cache hands it one miss at a time, as a block address. The block checks a one-entry stream buffer. If the buffer does not hold the block, the block fetches the demanded block from memory and returns it to the cache. It then fetches the next sequential block into the buffer, and that block does not go to the cache. If the buffer does hold the block, that block moves into the cache without a demand fetch, and a prefetch of the block after it refills the buffer.

A block is four 32-bit words: word i sits at bits [32i+31:32i] of the 128-bit block bus. Addresses are block addresses, ADDR_W bits wide, and the next block address wraps modulo 2^ADDR_W.

Every data path is a valid/ready channel, and a transfer takes place on a clock edge where both valid and ready are high. Once a sender raises valid, it holds valid and its payload unchanged until ready. A receiver may hold ready low for any number of cycles. Memory returns responses in request order, and the block keeps at most one memory request outstanding. The miss channel stays not ready from the moment a miss is taken until that miss has been filled and its prefetch has returned.

Top module: `istream_prefetch_buf`

## Requirements
- R1: After reset the buffer is invalid, `miss_ready` is high, and `fill_valid`, `mreq_valid` and `mrsp_ready` are low.
- R2: A miss whose address is not held in a valid buffer issues exactly two memory requests: first the miss address A, then A+1.
- R3: For a miss that also misses the buffer, the single fill carries address A and the block that memory returned for A, unchanged.
- R4: Every accepted miss produces exactly one fill. A prefetched block never reaches the fill port on its own.
- R5: A miss whose address equals the tag of a valid buffer entry issues no request for A. Its fill carries A and the block that was prefetched for A.
- R6: After a buffer hit has been filled, one request for A+1 is issued. The buffer is refilled from that request's response.
- R7: No new miss is accepted while a memory response is still outstanding or while the previous miss is unfinished.
- R8: The next-block address wraps: a miss at the all-ones address prefetches address 0, and a later miss at 0 hits the buffer.
- R9: While `fill_valid` or `mreq_valid` is high and the matching ready is low, the valid stays high and the address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | Cache presents a miss |
| miss_ready | output | 1 | Block accepts the miss |
| miss_addr | input | ADDR_W | Block address that missed |
| fill_valid | output | 1 | Block for the cache is present |
| fill_ready | input | 1 | Cache takes the fill |
| fill_addr | output | ADDR_W | Block address of the fill |
| fill_data | output | 128 | Fill block, four 32-bit words |
| mreq_valid | output | 1 | Memory read request present |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | ADDR_W | Requested block address |
| mrsp_valid | input | 1 | Memory response present |
| mrsp_ready | output | 1 | Block accepts the response |
| mrsp_data | input | 128 | Response block |

## Verification
The bench walks runs of sequential misses so that the buffer hits several times in a row. A design that did not promote the block would repeat the demand fetch, and one that did not refill the buffer would miss on the third block. Jumps to unrelated addresses check that a stale buffer entry is dropped and that both requests restart at the new address. A miss at the all-ones address checks the wrap to zero, and a design with an extra address bit would fail to hit on the following miss at 0. The bench stalls the fill and request ready signals and varies memory latency. It raises each new miss the moment the previous fill completes. A design that compared the buffer before the prefetch returned would then issue a needless demand fetch, and one that dropped the payload under stall would deliver corrupt blocks.

// File: rtl/ispf_pkg.sv
package ispf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DREQ = 3'd1,
    ST_DRSP = 3'd2,
    ST_FILL = 3'd3,
    ST_PREQ = 3'd4
  } ispf_state_e;
endpackage

// File: rtl/ispf_store.sv
module ispf_store #(
  parameter int ADDR_W = 28,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  localparam int BLK_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_tag_i,
  input  logic [BLK_W-1:0]  load_blk_i,
  input  logic [ADDR_W-1:0] probe_i,
  output logic              hit_o,
  output logic [BLK_W-1:0]  blk_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      tag_q   <= load_tag_i;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (load_i) word_q <= load_blk_i[w*WORD_W +: WORD_W];
    end
    assign blk_o[w*WORD_W +: WORD_W] = word_q;
  end

  assign hit_o = valid_q && (tag_q == probe_i);
endmodule

// File: rtl/ispf_fsm.sv
module ispf_fsm
  import ispf_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  output logic              miss_ready_o,
  input  logic              buf_hit_i,
  output logic              fill_valid_o,
  input  logic              fill_ready_i,
  output logic              from_buf_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              mreq_valid_o,
  input  logic              mreq_ready_i,
  output logic [ADDR_W-1:0] mreq_addr_o,
  input  logic              mrsp_valid_i,
  output logic              mrsp_ready_o,
  output logic              buf_clear_o,
  output logic              buf_load_o,
  output logic [ADDR_W-1:0] buf_tag_o,
  output logic              dem_load_o
);
  ispf_state_e       state_q, state_d;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] pf_tag_q;
  logic              pf_pend_q;
  logic              from_buf_q;
  logic [ADDR_W-1:0] next_blk;
  logic              accept;

  assign next_blk     = cur_q + ADDR_W'(1);
  assign miss_ready_o = (state_q == ST_IDLE) && !pf_pend_q;
  assign accept       = miss_valid_i && miss_ready_o;

  assign mreq_valid_o = (state_q == ST_DREQ) || (state_q == ST_PREQ);
  assign mreq_addr_o  = (state_q == ST_PREQ) ? next_blk : cur_q;
  assign mrsp_ready_o = (state_q == ST_DRSP) || pf_pend_q;
  assign fill_valid_o = (state_q == ST_FILL);
  assign from_buf_o   = from_buf_q;
  assign cur_addr_o   = cur_q;

  assign buf_clear_o  = accept;
  assign buf_load_o   = pf_pend_q && mrsp_valid_i;
  assign buf_tag_o    = pf_tag_q;
  assign dem_load_o   = (state_q == ST_DRSP) && mrsp_valid_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = buf_hit_i ? ST_FILL : ST_DREQ;
      ST_DREQ: if (mreq_ready_i) state_d = ST_DRSP;
      ST_DRSP: if (mrsp_valid_i) state_d = ST_FILL;
      ST_FILL: if (fill_ready_i) state_d = ST_PREQ;
      ST_PREQ: if (mreq_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      pf_tag_q   <= '0;
      pf_pend_q  <= 1'b0;
      from_buf_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cur_q      <= miss_addr_i;
        from_buf_q <= buf_hit_i;
      end
      if ((state_q == ST_PREQ) && mreq_ready_i) begin
        pf_pend_q <= 1'b1;
        pf_tag_q  <= next_blk;
      end else if (pf_pend_q && mrsp_valid_i) begin
        pf_pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/istream_prefetch_buf.sv
module istream_prefetch_buf #(
  parameter int ADDR_W = 28,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  localparam int BLK_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              fill_valid,
  input  logic              fill_ready,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [BLK_W-1:0]  fill_data,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [ADDR_W-1:0] mreq_addr,
  input  logic              mrsp_valid,
  output logic              mrsp_ready,
  input  logic [BLK_W-1:0]  mrsp_data
);
  logic              buf_hit, buf_clear, buf_load, dem_load, from_buf;
  logic [ADDR_W-1:0] buf_tag;
  logic [BLK_W-1:0]  buf_blk;
  logic [BLK_W-1:0]  dem_q;

  ispf_fsm #(.ADDR_W(ADDR_W)) i_fsm (
    .clk          (clk),
    .rst          (rst),
    .miss_valid_i (miss_valid),
    .miss_addr_i  (miss_addr),
    .miss_ready_o (miss_ready),
    .buf_hit_i    (buf_hit),
    .fill_valid_o (fill_valid),
    .fill_ready_i (fill_ready),
    .from_buf_o   (from_buf),
    .cur_addr_o   (fill_addr),
    .mreq_valid_o (mreq_valid),
    .mreq_ready_i (mreq_ready),
    .mreq_addr_o  (mreq_addr),
    .mrsp_valid_i (mrsp_valid),
    .mrsp_ready_o (mrsp_ready),
    .buf_clear_o  (buf_clear),
    .buf_load_o   (buf_load),
    .buf_tag_o    (buf_tag),
    .dem_load_o   (dem_load)
  );

  ispf_store #(.ADDR_W(ADDR_W), .WORDS(WORDS), .WORD_W(WORD_W)) i_stream (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (buf_clear),
    .load_i     (buf_load),
    .load_tag_i (buf_tag),
    .load_blk_i (mrsp_data),
    .probe_i    (miss_addr),
    .hit_o      (buf_hit),
    .blk_o      (buf_blk)
  );

  always_ff @(posedge clk) begin
    if (dem_load) dem_q <= mrsp_data;
  end

  assign fill_data = from_buf ? buf_blk : dem_q;
endmodule

// File: rtl/ispf_checker.sv
module ispf_checker #(
  parameter int ADDR_W = 28,
  parameter int BLK_W  = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic [ADDR_W-1:0] fill_addr,
  input logic [BLK_W-1:0]  fill_data,
  input logic              mreq_valid,
  input logic              mreq_ready,
  input logic [ADDR_W-1:0] mreq_addr,
  input logic              mrsp_valid,
  input logic              mrsp_ready
);
  logic [1:0] mem_out_q;
  logic [1:0] miss_out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_out_q  <= '0;
      miss_out_q <= '0;
    end else begin
      mem_out_q  <= mem_out_q + 2'(mreq_valid && mreq_ready) - 2'(mrsp_valid && mrsp_ready);
      miss_out_q <= miss_out_q + 2'(miss_valid && miss_ready) - 2'(fill_valid && fill_ready);
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!fill_valid && !mreq_valid && !mrsp_ready && miss_ready));

  p_one_request_r2: assert property (@(posedge clk) disable iff (rst)
    mreq_valid |-> (mem_out_q == 2'd0));

  p_rsp_expected_r3: assert property (@(posedge clk) disable iff (rst)
    mrsp_ready |-> (mem_out_q == 2'd1));

  p_fill_per_miss_r4: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> (miss_out_q == 2'd1));

  p_miss_waits_r7: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready) |-> (mem_out_q == 2'd0 && miss_out_q == 2'd0));

  p_fill_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_addr) && $stable(fill_data)));

  p_mreq_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)));
endmodule

bind istream_prefetch_buf ispf_checker #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) i_ispf_checker (
  .clk        (clk),
  .rst        (rst),
  .miss_valid (miss_valid),
  .miss_ready (miss_ready),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready),
  .fill_addr  (fill_addr),
  .fill_data  (fill_data),
  .mreq_valid (mreq_valid),
  .mreq_ready (mreq_ready),
  .mreq_addr  (mreq_addr),
  .mrsp_valid (mrsp_valid),
  .mrsp_ready (mrsp_ready)
);

// File: tb/test_istream_prefetch_buf.sv
module test_istream_prefetch_buf;
  localparam int AW = 28;
  localparam int BW = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          miss_valid = 1'b0;
  logic          miss_ready;
  logic [AW-1:0] miss_addr = '0;
  logic          fill_valid;
  logic          fill_ready = 1'b0;
  logic [AW-1:0] fill_addr;
  logic [BW-1:0] fill_data;
  logic          mreq_valid;
  logic          mreq_ready = 1'b0;
  logic [AW-1:0] mreq_addr;
  logic          mrsp_valid = 1'b0;
  logic          mrsp_ready;
  logic [BW-1:0] mrsp_data = '0;

  istream_prefetch_buf i_istream_prefetch_buf (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int acc_cnt = 0;
  int fill_cnt = 0;
  int rsp_cnt = 0;
  int rsp_seen = 0;
  int cyc = 0;
  int dly = 0;
  bit done = 0;

  // reference model state
  logic [AW-1:0] mem_q[$];
  logic [AW-1:0] exp_req[$];
  string         exp_req_tag[$];
  logic [AW-1:0] exp_fill[$];
  string         exp_fill_tag[$];
  bit            mb_valid = 0;
  logic [AW-1:0] mb_tag = '0;
  bit            fstall = 0;
  logic [AW-1:0] fstall_addr;
  logic [BW-1:0] fstall_data;
  bit            rstall = 0;
  logic [AW-1:0] rstall_addr;

  function automatic logic [BW-1:0] blk(logic [AW-1:0] a);
    logic [BW-1:0] r;
    for (int i = 0; i < 4; i++) r[32*i +: 32] = {a, 2'(i), 2'b00} ^ 32'hC3A5_0000;
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // monitor and reference model, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (fstall) begin
        chk(fill_valid && fill_addr == fstall_addr && fill_data == fstall_data, "R9",
            "fill held under stall", {fill_valid, fill_addr}, {1'b1, fstall_addr});
      end
      if (rstall) begin
        chk(mreq_valid && mreq_addr == rstall_addr, "R9", "request held under stall",
            {mreq_valid, mreq_addr}, {1'b1, rstall_addr});
      end
      fstall = fill_valid && !fill_ready;
      fstall_addr = fill_addr;
      fstall_data = fill_data;
      rstall = mreq_valid && !mreq_ready;
      rstall_addr = mreq_addr;

      if (miss_valid && miss_ready) begin
        chk(mem_q.size() == 0 && exp_req.size() == 0 && exp_fill.size() == 0, "R7",
            "miss taken with work outstanding", mem_q.size() + exp_req.size(), 0);
        if (mb_valid && mb_tag == miss_addr) begin
          exp_req.push_back(miss_addr + AW'(1));
          exp_req_tag.push_back((miss_addr + AW'(1)) == '0 ? "R8" : "R6");
          exp_fill.push_back(miss_addr);
          exp_fill_tag.push_back("R5");
        end else begin
          exp_req.push_back(miss_addr);
          exp_req_tag.push_back("R2");
          exp_req.push_back(miss_addr + AW'(1));
          exp_req_tag.push_back((miss_addr + AW'(1)) == '0 ? "R8" : "R2");
          exp_fill.push_back(miss_addr);
          exp_fill_tag.push_back("R3");
        end
        mb_valid = 1;
        mb_tag = miss_addr + AW'(1);
        acc_cnt++;
      end

      if (mreq_valid && mreq_ready) begin
        if (exp_req.size() == 0) begin
          chk(0, "R5", "unexpected memory request", mreq_addr, 0);
        end else begin
          chk(mreq_addr == exp_req[0], exp_req_tag[0], "memory request address", mreq_addr, exp_req[0]);
          void'(exp_req.pop_front());
          void'(exp_req_tag.pop_front());
        end
        mem_q.push_back(mreq_addr);
      end

      if (fill_valid && fill_ready) begin
        if (exp_fill.size() == 0) begin
          chk(0, "R4", "fill without a pending miss", fill_addr, 0);
        end else begin
          chk(fill_addr == exp_fill[0], exp_fill_tag[0], "fill address", fill_addr, exp_fill[0]);
          chk(fill_data == blk(exp_fill[0]), exp_fill_tag[0], "fill data", fill_data, blk(exp_fill[0]));
          void'(exp_fill.pop_front());
          void'(exp_fill_tag.pop_front());
        end
        fill_cnt++;
      end

      if (mrsp_valid && mrsp_ready) begin
        if (mem_q.size() > 0) void'(mem_q.pop_front());
        rsp_cnt++;
      end
    end
  end

  // memory and back-pressure driver, just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (!rst) begin
      mreq_ready = (cyc % 5) != 1;
      fill_ready = (cyc % 3) != 0;
      if (mrsp_valid && rsp_cnt != rsp_seen) begin
        mrsp_valid = 1'b0;
        rsp_seen = rsp_cnt;
        dly = 1 + (cyc % 4);
      end else if (!mrsp_valid && mem_q.size() > 0) begin
        if (dly == 0) begin
          mrsp_valid = 1'b1;
          mrsp_data = blk(mem_q[0]);
        end else begin
          dly--;
        end
      end
    end
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL R7 watchdog expired: actual %0d expected %0d cycles max", cyc, 20000);
      finish_run();
    end
  end

  task automatic do_miss(logic [AW-1:0] a);
    int a0 = acc_cnt;
    int f0 = fill_cnt;
    @(posedge clk);
    #2;
    miss_valid = 1'b1;
    miss_addr = a;
    wait (acc_cnt != a0);
    @(posedge clk);
    #2;
    miss_valid = 1'b0;
    wait (fill_cnt != f0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    @(negedge clk);
    chk(miss_ready && !fill_valid && !mreq_valid && !mrsp_ready, "R1", "idle after reset",
        {miss_ready, fill_valid, mreq_valid, mrsp_ready}, 4'b1000);

    do_miss(28'h0000100);   // cold miss
    do_miss(28'h0000101);   // buffer hit
    do_miss(28'h0000102);   // buffer hit after refill
    do_miss(28'h0002000);   // jump: stale entry dropped
    do_miss(28'h0002001);   // hit
    do_miss(28'h0000100);   // back: buffer holds 0x2002, miss
    do_miss(28'hFFFFFFF);   // wraps prefetch to 0
    do_miss(28'h0000000);   // hit on wrapped block
    do_miss(28'h0000005);   // miss
    do_miss(28'h0000007);   // not the next block, miss
    do_miss(28'h0000008);   // hit
    do_miss(28'h0000009);   // hit

    wait (mem_q.size() == 0 && exp_req.size() == 0 && !mrsp_valid);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(fill_cnt == acc_cnt && exp_fill.size() == 0, "R4", "one fill per miss",
        fill_cnt, acc_cnt);
    chk(!fill_valid && !mreq_valid && miss_ready, "R6", "idle after final prefetch returned",
        {fill_valid, mreq_valid, miss_ready}, 3'b001);
    done = 1;
    finish_run();
  end
endmodule